// File: doc/BRIEF.md
# UART Boot Download Engine

This block takes in a serial boot download one byte at a time from a UART receiver. It works in half duplex. Every byte it accepts goes back to the host on the transmit side, and the next byte is not taken until that echo has been accepted. The download has four phases in a fixed order:

1. An 8-byte password, which is compared with a stored 64-bit value.
2. A 4-byte load address.
3. A 4-byte length word. Its top bit is a mandatory mode flag and its low 31 bits are the payload byte count.
4. The payload.

Payload bytes are packed into 32-bit words and written through a synchronous word-write port, starting at the load address. When the last counted byte has been echoed, the engine raises a branch request that carries the load address.

A wrong password or a cleared mode flag drops the engine into a static locked state. Only reset leaves that state. The UART serializer, baud detection and the actual processor jump belong to the surrounding logic.

Top module: `serial_boot_loader`

## Requirements
- R1: After reset, rx_ready is 1, and tx_valid, mem_we, branch_req and locked are all 0.
- R2: Each byte accepted on rx_valid && rx_ready appears on tx_data with tx_valid high from the next cycle. It is held stable until tx_ready is seen high.
- R3: rx_ready is 0 while an echo is pending, so no byte is accepted until the previous echo has been taken.
- R4: The first 8 bytes form the password, with the most significant byte first. If they differ from PASSWORD, locked rises. From then on rx_ready stays 0, and nothing more is echoed, written or branched until reset.
- R5: The next 4 bytes, most significant first, form the load address. This address is the first write address and the branch target.
- R6: The next 4 bytes, most significant first, form the length word. Bit 31 must be 1, or the engine locks as in R4. Bits 30:0 give the payload byte count.
- R7: Payload bytes are packed big-endian: the first byte of each group of four goes to bits 31:24. Word k is written with a one-cycle mem_we pulse at address load + 4k, with mem_be = 4'b1111 for a full word. mem_be bit 3 enables bits 31:24.
- R8: A final partial word of 1, 2 or 3 bytes has its unused low bytes set to zero. Its mem_be is 4'b1000, 4'b1100 or 4'b1110 respectively.
- R9: After the last payload byte has been echoed, branch_req goes to 1 with branch_addr equal to the load address. Both stay put, rx_ready stays 0 and nothing more is transmitted.
- R10: A byte count of zero causes no write. branch_req rises as soon as the echo of the last length byte has been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Received byte available |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Engine takes a byte this cycle |
| tx_valid | output | 1 | Echo byte pending |
| tx_data | output | 8 | Echo byte |
| tx_ready | input | 1 | Transmitter takes the echo |
| mem_we | output | 1 | Word write strobe |
| mem_addr | output | 32 | Word write address |
| mem_wdata | output | 32 | Packed write data |
| mem_be | output | 4 | Byte enables, bit 3 for bits 31:24 |
| branch_req | output | 1 | Download complete, jump requested |
| branch_addr | output | 32 | Jump target (load address) |
| locked | output | 1 | Static state after a failed check |

## Verification
The bound checker watches several rules on every cycle:

- each accepted byte returns as the next echo;
- no byte is taken while an echo is pending;
- the echo holds until it is accepted;
- the locked and branch states are sticky, and never occur together;
- every write enables the top byte.

Password comparison, field ordering, big-endian packing, write addresses, partial-word masks and the zero-count branch depend on whole downloads. Only the bench scenarios show them, comparing the captured writes and the branch outcome against values the bench computes itself.

// File: rtl/serial_boot_loader.sv
module serial_boot_loader #(
  parameter logic [63:0] PASSWORD = 64'h0123_4567_89AB_CDEF,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  output logic          rx_ready,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  input  logic          tx_ready,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [DW/8-1:0] mem_be,
  output logic          branch_req,
  output logic [DW-1:0] branch_addr,
  output logic          locked
);
  localparam int BYTES = DW / 8;
  localparam int IW = $clog2(BYTES);

  typedef enum logic [2:0] {ST_KEY, ST_ADDR, ST_LEN, ST_DATA, ST_GO, ST_LOCK} st_t;
  st_t state;

  logic [63:0]   shreg;
  logic [2:0]    bcnt;
  logic [DW-1:0] load_addr, wptr, wbuf;
  logic [DW-2:0] remain;
  logic [IW-1:0] widx;

  wire           take    = rx_valid && rx_ready;
  wire [63:0]    sh_next = {shreg[55:0], rx_data};
  wire [DW-1:0]  merged  = wbuf | ({{(DW-8){1'b0}}, rx_data} << (8 * (BYTES - 1 - int'(widx))));
  wire           last_b  = (remain == 1);
  wire           flush   = last_b || (widx == IW'(BYTES - 1));

  logic [BYTES-1:0] be_now;
  always_comb
    for (int i = 0; i < BYTES; i++)
      be_now[BYTES-1-i] = (int'(widx) >= i);

  assign rx_ready    = !tx_valid && (state inside {ST_KEY, ST_ADDR, ST_LEN, ST_DATA});
  assign branch_req  = (state == ST_GO) && !tx_valid;
  assign branch_addr = load_addr;
  assign locked      = (state == ST_LOCK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_KEY;
      shreg     <= '0;
      bcnt      <= '0;
      load_addr <= '0;
      wptr      <= '0;
      wbuf      <= '0;
      remain    <= '0;
      widx      <= '0;
      tx_valid  <= 1'b0;
      tx_data   <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_be    <= '0;
    end else begin
      mem_we <= 1'b0;
      if (take) begin
        tx_valid <= 1'b1;
        tx_data  <= rx_data;
        shreg    <= sh_next;
        bcnt     <= bcnt + 3'd1;
        case (state)
          ST_KEY:
            if (bcnt == 3'd7) begin
              bcnt  <= '0;
              state <= (sh_next == PASSWORD) ? ST_ADDR : ST_LOCK;
            end
          ST_ADDR: begin
            load_addr <= sh_next[DW-1:0];
            if (bcnt == 3'd3) begin
              bcnt  <= '0;
              state <= ST_LEN;
            end
          end
          ST_LEN:
            if (bcnt == 3'd3) begin
              bcnt   <= '0;
              remain <= sh_next[DW-2:0];
              wptr   <= load_addr;
              wbuf   <= '0;
              widx   <= '0;
              if (!sh_next[DW-1])
                state <= ST_LOCK;
              else if (sh_next[DW-2:0] == '0)
                state <= ST_GO;
              else
                state <= ST_DATA;
            end
          ST_DATA: begin
            remain <= remain - 1'b1;
            if (flush) begin
              mem_we    <= 1'b1;
              mem_addr  <= wptr;
              mem_wdata <= merged;
              mem_be    <= be_now;
              wptr      <= wptr + DW'(BYTES);
              wbuf      <= '0;
              widx      <= '0;
            end else begin
              wbuf <= merged;
              widx <= widx + 1'b1;
            end
            if (last_b) state <= ST_GO;
          end
          default: ;
        endcase
      end else if (tx_valid && tx_ready) begin
        tx_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/serial_boot_loader_chk.sv
module serial_boot_loader_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_valid,
  input logic [7:0]  rx_data,
  input logic        rx_ready,
  input logic        tx_valid,
  input logic [7:0]  tx_data,
  input logic        tx_ready,
  input logic        mem_we,
  input logic [3:0]  mem_be,
  input logic        branch_req,
  input logic [31:0] branch_addr,
  input logic        locked
);
  AST_ECHO_NEXT: assert property (@(posedge clk) disable iff (!rst_n) rx_valid && rx_ready |=> tx_valid && tx_data == $past(rx_data)); // R2
  AST_ECHO_HOLD: assert property (@(posedge clk) disable iff (!rst_n) tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)); // R2
  AST_NO_RX_IN_ECHO: assert property (@(posedge clk) disable iff (!rst_n) tx_valid |-> !rx_ready); // R3
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n) locked |=> locked && !rx_ready && !mem_we); // R4
  AST_BRANCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n) branch_req |=> branch_req && $stable(branch_addr) && !rx_ready && !tx_valid); // R9
  AST_LOCK_NO_BRANCH: assert property (@(posedge clk) disable iff (!rst_n) !(locked && branch_req)); // R4
  AST_TOP_BYTE_EN: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> mem_be[3] && $countones(mem_be) >= 1); // R8
endmodule

bind serial_boot_loader serial_boot_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
  .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .mem_we(mem_we),
  .mem_be(mem_be), .branch_req(branch_req), .branch_addr(branch_addr), .locked(locked)
);

// File: tb/serial_boot_loader_bench.sv
module serial_boot_loader_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] KEY = 64'h0123_4567_89AB_CDEF;

  logic clk = 0, rst_n = 0;
  logic rx_valid = 0, tx_ready = 0;
  logic [7:0] rx_data = 0;
  logic rx_ready, tx_valid, mem_we, branch_req, locked;
  logic [7:0] tx_data;
  logic [31:0] mem_addr, mem_wdata, branch_addr;
  logic [3:0] mem_be;

  int errors = 0, checks = 0, cycles = 0;
  int nw = 0;
  logic [31:0] wa [64];
  logic [31:0] wd [64];
  logic [3:0]  wb [64];
  logic [7:0]  pay [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_boot_loader #(.PASSWORD(KEY)) u_serial_boot_loader (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .branch_req(branch_req), .branch_addr(branch_addr), .locked(locked));

  always @(negedge clk) if (rst_n && mem_we && nw < 64) begin
    wa[nw] = mem_addr; wd[nw] = mem_wdata; wb[nw] = mem_be; nw++;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: act=%0d cycles exp<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input int k, input int n);
    logic [31:0] w = 0;
    for (int j = 0; j < 4; j++)
      if (4*k + j < n) w[31-8*j -: 8] = pay[4*k + j];
    return w;
  endfunction

  function automatic logic [3:0] exp_be(input int k, input int n);
    int left = n - 4*k;
    if (left >= 4) return 4'b1111;
    if (left == 3) return 4'b1110;
    if (left == 2) return 4'b1100;
    return 4'b1000;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 0; rx_valid = 0; tx_ready = 0;
    repeat (2) @(negedge clk);
    rst_n = 1; nw = 0;
    @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    rx_valid = 1; rx_data = b;
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
    rx_valid = 0;
    chk("R2 echo", {23'd0, tx_valid, tx_data}, {23'd0, 1'b1, b});
    chk("R3 hold-off", {31'd0, rx_ready}, 32'd0);
    repeat ($urandom % 3) @(negedge clk);
    chk("R2 echo held", {23'd0, tx_valid, tx_data}, {23'd0, 1'b1, b});
    tx_ready = 1;
    @(negedge clk);
    tx_ready = 0;
  endtask

  task automatic header(input logic [63:0] pw, input logic [31:0] la, input logic [31:0] lw);
    for (int i = 0; i < 8; i++) send_byte(pw[63-8*i -: 8]);
    if (pw == KEY) begin
      for (int i = 0; i < 4; i++) send_byte(la[31-8*i -: 8]);
      for (int i = 0; i < 4; i++) send_byte(lw[31-8*i -: 8]);
    end
  endtask

  task automatic quiet_after(input string req);
    rx_valid = 1; rx_data = 8'h5A;
    repeat (3) @(negedge clk);
    chk(req, {30'd0, rx_ready, tx_valid}, 32'd0);
    rx_valid = 0;
  endtask

  task automatic good_run(input logic [31:0] la, input int n);
    do_reset();
    for (int i = 0; i < n; i++) pay[i] = 8'($urandom);
    header(KEY, la, 32'h8000_0000 | n);
    for (int i = 0; i < n; i++) send_byte(pay[i]);
    @(negedge clk);
    chk(n == 0 ? "R10 zero-count branch" : "R9 branch", {31'd0, branch_req}, 32'd1);
    chk("R5 R9 branch address", branch_addr, la);
    chk("R4 not locked", {31'd0, locked}, 32'd0);
    chk("R7 word count", nw, (n + 3) / 4);
    for (int k = 0; k < (n + 3) / 4 && k < nw; k++) begin
      chk("R7 address", wa[k], la + 4*k);
      chk((4*k + 4 > n) ? "R8 partial data" : "R7 data", wd[k], exp_word(k, n));
      chk((4*k + 4 > n) ? "R8 partial mask" : "R7 mask", {28'd0, wb[k]}, {28'd0, exp_be(k, n)});
    end
    quiet_after("R9 silent after branch");
  endtask

  initial begin
    void'($urandom(32'h5EED));
    @(negedge clk);
    chk("R1 reset", {27'd0, rx_ready, tx_valid, mem_we, branch_req, locked}, 32'b10000);
    do_reset();
    chk("R1 reset", {27'd0, rx_ready, tx_valid, mem_we, branch_req, locked}, 32'b10000);

    good_run(32'h4000_0100, 8);
    good_run(32'h4000_0200, 9);
    good_run(32'h4000_0300, 10);
    good_run(32'h4000_0400, 11);
    good_run(32'h4000_0500, 0);
    good_run(32'h1234_5678, 1);

    do_reset();
    header(KEY ^ 64'h1, 32'h0, 32'h0);
    @(negedge clk);
    chk("R4 bad password locks", {30'd0, locked, branch_req}, 32'b10);
    quiet_after("R4 locked ignores input");
    chk("R4 no writes when locked", nw, 0);

    do_reset();
    header({KEY[7:0], KEY[63:8]}, 32'h0, 32'h0);
    @(negedge clk);
    chk("R4 byte order matters", {31'd0, locked}, 32'd1);

    do_reset();
    header(KEY, 32'h4000_0000, 32'h0000_0004);
    @(negedge clk);
    chk("R6 flag clear locks", {30'd0, locked, branch_req}, 32'b10);
    quiet_after("R6 locked ignores payload");
    chk("R6 no writes", nw, 0);

    for (int r = 0; r < 10; r++)
      good_run({$urandom} & 32'hFFFF_FFFC, 1 + ($urandom % 40));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule